// File: doc/BRIEF.md
# Inter-Processor Doorbell Mailbox

This block lets one processor ring a doorbell on another. It keeps three physical channels. Channel 0 is low priority non-secure, channel 1 is high priority non-secure and channel 2 is secure. Each channel holds a 32-bit event word, and every bit of that word is an independent subchannel. A sender raises an event by writing ones to a channel's set register. The receiver reads the status register, consumes the data tied to those events, and then writes ones to the clear register. Each channel drives one interrupt line, which is the registered OR of its 32 bits.

Software reaches the block through a single-cycle, APB-like register port. Each access carries a secure qualifier. The secure channel filters out non-secure traffic: such writes are dropped, such reads return zero, and the access is flagged with an error pulse in the same cycle. A client names an event by a channel index and a bit index from 0 to 31. For example, channel 1, subchannel 4 is bit 4 of the high-priority word.

Top module: `mbx_top`

## Requirements
- R1: Channel register blocks sit at byte address 0x000 (channel 0, low-priority non-secure), 0x020 (channel 1, high-priority non-secure) and 0x200 (channel 2, secure). Within a block, status is at +0x00, set is at +0x08 and clear is at +0x10. Subchannel b is bit b of the channel's 32-bit word.
- R2: A write to a set register turns on every status bit whose write-data bit is 1 and leaves the other bits unchanged. Reads of a set register return zero.
- R3: A write to a clear register turns off every status bit whose write-data bit is 1 and leaves the other bits unchanged. Reads of a clear register return zero.
- R4: A read of a status register returns the channel's current 32-bit word on `acc_rdata` in the same cycle as the access.
- R5: `irq_out[c]` is 1 exactly when any bit of channel c's word is set. It rises in the cycle after the write that sets a bit and falls in the cycle after the write that clears the last set bit.
- R6: A non-secure write (`acc_secure`=0) to any register of channel 2 leaves channel 2's word unchanged.
- R7: A non-secure read of a channel 2 register returns zero. Any non-secure access to a channel 2 register drives `acc_err` to 1 in that cycle. `acc_err` is 0 for every other access, including secure accesses to any channel.
- R8: Accesses to addresses other than the nine mapped registers read zero, change no state and raise no error.
- R9: While `rst` is 1 at a clock edge, all status words clear and all interrupt outputs go to 0.
- R10: Reads and idle cycles never change any status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | 1 = secure access |
| acc_addr | input | 12 | Byte address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the access cycle |
| acc_err | output | 1 | Access to secure channel was refused |
| irq_out | output | 3 | One interrupt per channel (index = channel) |

## Verification
A corrupted status bit appears at a later status read, usually in the same cycle as that read. If it is the only set bit, it also shows one cycle after the bad update as a wrong level on that channel's interrupt line. A decode fault that routes a set or clear to the wrong channel appears at the next status read of either channel. A fault in the security filter appears at once as a missing or spurious error pulse, or as secure data leaking into a non-secure read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NUM_CH = 3;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;
    localparam int BLK_W  = 5;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int SEC_CH = NUM_CH - 1;

    localparam logic [BLK_W-1:0] OFF_STAT = 5'h00;
    localparam logic [BLK_W-1:0] OFF_SET  = 5'h08;
    localparam logic [BLK_W-1:0] OFF_CLR  = 5'h10;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_STAT = 2'd1,
        REG_SET  = 2'd2,
        REG_CLR  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
        reg_kind_e       kind;
    } dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] set_m;
        logic [WORD_W-1:0] clr_m;
    } upd_t;

    function automatic logic [ADDR_W-1:0] ch_base(input int c);
        case (c)
            0:       return 12'h000;
            1:       return 12'h020;
            default: return 12'h200;
        endcase
    endfunction

    function automatic reg_kind_e kind_of(input logic [BLK_W-1:0] off);
        case (off)
            OFF_STAT: return REG_STAT;
            OFF_SET:  return REG_SET;
            OFF_CLR:  return REG_CLR;
            default:  return REG_NONE;
        endcase
    endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              secure,
    output dec_t              dec,
    output logic              deny
);
    reg_kind_e kind;

    always_comb begin
        kind = kind_of(addr[BLK_W-1:0]);
        dec  = '{hit: 1'b0, ch: '0, kind: REG_NONE};
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr[ADDR_W-1:BLK_W] == ch_base(c)[ADDR_W-1:BLK_W] &&
                kind != REG_NONE) begin
                dec.hit  = 1'b1;
                dec.ch   = CH_W'(c);
                dec.kind = kind;
            end
        end
        deny = dec.hit && (dec.ch == CH_W'(SEC_CH)) && !secure;
    end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  upd_t              upd,
    output logic [WORD_W-1:0] stat,
    output logic              irq
);
    logic [WORD_W-1:0] stat_n;

    // set wins over clear on the same bit
    always_comb stat_n = (stat & ~upd.clr_m) | upd.set_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            irq  <= 1'b0;
        end else begin
            stat <= stat_n;
            irq  <= |stat_n;
        end
    end
endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_secure,
    input  logic [11:0]       acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    output logic              acc_err,
    output logic [2:0]        irq_out
);
    dec_t dec;
    logic deny;
    logic grant;
    logic [WORD_W-1:0]        stat [NUM_CH];
    logic [NUM_CH*WORD_W-1:0] stat_flat;

    mbx_decode dec_i (
        .addr   (acc_addr),
        .secure (acc_secure),
        .dec    (dec),
        .deny   (deny)
    );

    assign grant = acc_valid && dec.hit && !deny;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        upd_t upd;
        always_comb begin
            upd.set_m = '0;
            upd.clr_m = '0;
            if (grant && acc_write && dec.ch == CH_W'(c)) begin
                if (dec.kind == REG_SET) upd.set_m = acc_wdata;
                if (dec.kind == REG_CLR) upd.clr_m = acc_wdata;
            end
        end
        mbx_channel ch_i (
            .clk  (clk),
            .rst  (rst),
            .upd  (upd),
            .stat (stat[c]),
            .irq  (irq_out[c])
        );
        assign stat_flat[c*WORD_W +: WORD_W] = stat[c];
    end

    always_comb begin
        acc_rdata = '0;
        if (grant && !acc_write && dec.kind == REG_STAT)
            acc_rdata = stat[dec.ch];
    end

    assign acc_err = acc_valid && deny;
endmodule

// File: rtl/mbx_top_chk.sv
module mbx_top_chk
    import mbx_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     acc_valid,
    input logic                     acc_write,
    input logic                     acc_secure,
    input logic [31:0]              acc_rdata,
    input logic                     acc_err,
    input logic [2:0]               irq_out,
    input logic [NUM_CH*WORD_W-1:0] stat_flat
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    always_ff @(posedge clk) begin
        if (rst_seen) begin
            AST_RESET_CLEAR: assert (irq_out == '0 && stat_flat == '0); // R9
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
        AST_IRQ_TRACKS_WORD: assert property (@(posedge clk) disable iff (rst)
            rst_seen == 1'b0 |-> irq_out[c] == |stat_flat[c*WORD_W +: WORD_W]); // R5
    end

    AST_SEC_WORD_GUARDED: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !acc_secure) |=>
            $stable(stat_flat[SEC_CH*WORD_W +: WORD_W])); // R6

    AST_ERR_ONLY_NS: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> (acc_valid && !acc_secure)); // R7

    AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_err && !acc_write) |-> acc_rdata == '0); // R7

    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write) |=> $stable(stat_flat)); // R10
endmodule

bind mbx_top mbx_top_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_secure (acc_secure),
    .acc_rdata  (acc_rdata),
    .acc_err    (acc_err),
    .irq_out    (irq_out),
    .stat_flat  (stat_flat)
);

// File: tb/mbx_top_tb_top.sv
module mbx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_secure = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_err;
    logic [2:0]  irq_out;

    int total = 0;
    int bad = 0;
    logic [31:0] model [3];

    typedef struct {
        logic        is_rd;
        logic [31:0] data;
        logic        err;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    mbx_top dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_secure(acc_secure), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_err(acc_err), .irq_out(irq_out)
    );

    // address model: returns channel index or -1, and register kind (0 stat,1 set,2 clr)
    function automatic int map_ch(input logic [11:0] a, output int kind);
        int ch;
        ch = -1;
        kind = -1;
        if (a[11:5] == 7'h00) ch = 0;
        else if (a[11:5] == 7'h01) ch = 1;
        else if (a[11:5] == 7'h10) ch = 2;
        case (a[4:0])
            5'h00: kind = 0;
            5'h08: kind = 1;
            5'h10: kind = 2;
            default: kind = -1;
        endcase
        if (kind < 0) ch = -1;
        return ch;
    endfunction

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          input logic sec, input string tag);
        item_t it;
        int kind;
        int ch;
        ch = map_ch(a, kind);
        it.is_rd = !wr;
        it.tag   = tag;
        it.err   = (ch == 2 && !sec);
        it.data  = (!wr && ch >= 0 && !it.err && kind == 0) ? model[ch] : 32'h0;
        sb_q.push_back(it);
        @(posedge clk);
        #1;
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_addr   = a;
        acc_wdata  = d;
        acc_secure = sec;
        @(posedge clk);
        #1;
        acc_valid = 1'b0;
        acc_write = 1'b0;
        if (wr && ch >= 0 && !it.err) begin
            if (kind == 1) model[ch] = model[ch] | d;
            if (kind == 2) model[ch] = model[ch] & ~d;
        end
    endtask

    // monitor: pops expected items while an access is on the port
    always @(negedge clk) begin
        if (acc_valid && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (acc_err !== it.err) begin
                bad++;
                $display("FAIL %s err actual=%0b expected=%0b", it.tag, acc_err, it.err);
            end
            if (it.is_rd) begin
                total++;
                if (acc_rdata !== it.data) begin
                    bad++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, acc_rdata, it.data);
                end
            end
        end
    end

    task automatic check_irq(input string tag);
        logic [2:0] e;
        @(negedge clk);
        for (int c = 0; c < 3; c++) e[c] = |model[c];
        total++;
        if (irq_out !== e) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq_out, e);
        end
    endtask

    task automatic rd_all(input string tag);
        access(1'b0, 12'h000, 0, 1'b1, tag);
        access(1'b0, 12'h020, 0, 1'b1, tag);
        access(1'b0, 12'h200, 0, 1'b1, tag);
    endtask

    initial begin
        for (int c = 0; c < 3; c++) model[c] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_irq("R9 reset irq");
        rd_all("R9 reset status");

        // set semantics, subchannel bits 0 and 31
        access(1'b1, 12'h008, 32'h8000_0001, 1'b0, "R2 set ch0");
        check_irq("R5 irq rise ch0");
        access(1'b0, 12'h000, 0, 1'b0, "R4 read ch0");
        access(1'b1, 12'h008, 32'h0000_0010, 1'b0, "R2 set more ch0");
        access(1'b0, 12'h000, 0, 1'b0, "R2 zeros keep bits");
        access(1'b0, 12'h008, 0, 1'b0, "R2 set reads zero");
        access(1'b0, 12'h010, 0, 1'b0, "R3 clear reads zero");

        // channel 1 subchannel 4
        access(1'b1, 12'h028, 32'h1 << 4, 1'b0, "R1 set ch1 sub4");
        check_irq("R5 irq ch1");
        access(1'b0, 12'h020, 0, 1'b0, "R1 read ch1");
        access(1'b0, 12'h000, 0, 1'b0, "R1 ch0 untouched");

        // clear semantics
        access(1'b1, 12'h010, 32'h0000_0001, 1'b0, "R3 clear bit0");
        access(1'b0, 12'h000, 0, 1'b0, "R3 read after clear");
        check_irq("R5 irq held");
        access(1'b1, 12'h010, 32'hFFFF_FFFF, 1'b0, "R3 clear all ch0");
        check_irq("R5 irq fall ch0");
        access(1'b1, 12'h030, 32'hFFFF_FFFF, 1'b1, "R7 secure clears ch1");
        check_irq("R5 irq fall ch1");

        // secure channel
        access(1'b1, 12'h208, 32'h0000_00A5, 1'b1, "R1 secure set ch2");
        check_irq("R5 irq ch2");
        access(1'b0, 12'h200, 0, 1'b1, "R4 secure read ch2");
        access(1'b1, 12'h210, 32'hFFFF_FFFF, 1'b0, "R6 ns clear ignored");
        access(1'b1, 12'h208, 32'hFF00_0000, 1'b0, "R6 ns set ignored");
        access(1'b0, 12'h200, 0, 1'b0, "R7 ns read zero");
        access(1'b0, 12'h200, 0, 1'b1, "R6 ch2 unchanged");
        check_irq("R6 irq ch2 kept");

        // unmapped space
        access(1'b1, 12'h004, 32'hFFFF_FFFF, 1'b0, "R8 unmapped wr");
        access(1'b1, 12'h040, 32'hFFFF_FFFF, 1'b1, "R8 unmapped wr2");
        access(1'b1, 12'h204, 32'hFFFF_FFFF, 1'b0, "R8 unmapped ns sec blk");
        access(1'b0, 12'h018, 0, 1'b0, "R8 unmapped rd");
        access(1'b0, 12'h3F0, 0, 1'b1, "R8 unmapped rd2");
        rd_all("R8 no state change");

        // reads and idle leave state
        access(1'b1, 12'h008, 32'h0F0F_0000, 1'b0, "R2 set ch0 again");
        repeat (5) @(posedge clk);
        for (int i = 0; i < 4; i++) access(1'b0, 12'h000, 0, 1'b0, "R10 repeated read");
        check_irq("R10 irq steady");

        // reset mid-run
        access(1'b1, 12'h028, 32'h0000_0003, 1'b0, "R2 set ch1 pre-reset");
        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        for (int c = 0; c < 3; c++) model[c] = '0;
        check_irq("R9 mid reset irq");
        rd_all("R9 mid reset status");

        repeat (2) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #50000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule